// File: doc/BRIEF.md
# Two-Phase Fork and Join Pipeline Stages

This block provides the two non-linear stages of a two-phase (transition-signalled) latch pipeline, in a clocked model. The fork stage captures one word from an upstream producer and presents it, with a single request wire, to two downstream branches. The join stage takes one word from each of two upstream branches and captures them together as one double-width word for a single consumer. Every handshake wire changes exactly once per item, and it never returns to zero.

Each stage holds a one-bit `done` phase register and a data register. A stage is open, meaning transparent, when its `done` phase equals the acknowledge it sees from downstream; this is the XNOR enable of a linear stage. On the fork, that acknowledge is the output of a state-holding C-element over the two branch acknowledges. On the join, the incoming request is the output of a C-element over the two branch requests. Each C-element is a registered cell that copies its inputs when they agree and otherwise keeps its value.

The top module holds one fork stage and one join stage. The two branch pipelines between them lie outside the block. A typical use is fork, then two independent FIFO pipelines, then join, so that each output word pairs the two branch results for the same input item.

Top module: `mt_fork_join`

## Requirements
- R1: After synchronous active-low reset, `in_ack`, `fork_req`, `join_ack` and `out_req` are 0, and `fork_data` and `out_data` are all zeros.
- R2: While the fork is empty, a toggle of `in_req` is captured at the next clock edge: `fork_req` and `in_ack` take the new `in_req` level, and `fork_data` takes `in_data`.
- R3: Once it has captured an item, the fork holds `fork_req` and `fork_data` unchanged, and takes no new input, until both `fork_ack_a` and `fork_ack_b` equal `fork_req`.
- R4: After the later of the two branch acknowledges reaches the `fork_req` level, the fork takes a pending input item at the second following clock edge.
- R5: Each C-element resets to 0, copies its inputs when all of them are equal, and otherwise keeps its previous value.
- R6: A toggle on only one of `join_req_a` and `join_req_b` leaves `out_req`, `out_data` and `join_ack` unchanged.
- R7: When both join requests differ from `join_ack` and the join is empty (`out_ack == out_req`), the join captures at the second clock edge after the later request toggle. `out_data` becomes {`join_data_a`, `join_data_b`}, with branch A in bits [2W-1:W], and `out_req` and `join_ack` toggle.
- R8: While `out_ack` differs from `out_req`, `out_data` and `out_req` stay unchanged whatever the join requests do. After `out_ack` matches, a pending pair is captured at the next clock edge.
- R9: With a fork feeding two FIFO branches of independent random delay that rejoin at the join, the n-th output word is {x_n, x_n}, where x_n is the n-th input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_req | input | 1 | Two-phase request from the upstream producer |
| in_data | input | W | Upstream data word |
| in_ack | output | 1 | Two-phase acknowledge to the upstream producer (fork phase) |
| fork_req | output | 1 | Request to both branches |
| fork_data | output | W | Captured fork word, sent to both branches |
| fork_ack_a | input | 1 | Acknowledge from branch A |
| fork_ack_b | input | 1 | Acknowledge from branch B |
| join_req_a | input | 1 | Request from branch A |
| join_data_a | input | W | Data from branch A |
| join_req_b | input | 1 | Request from branch B |
| join_data_b | input | W | Data from branch B |
| join_ack | output | 1 | Acknowledge to both branches (join phase) |
| out_req | output | 1 | Request to the downstream consumer |
| out_data | output | 2W | Joined word {A, B} |
| out_ack | input | 1 | Acknowledge from the downstream consumer |

## Verification
Suppose a C-element updates while its inputs disagree. The fork then reopens after only one branch has acknowledged, and within one item a branch sees `fork_data` change before it has taken the word, or the join pairs words from different input indices. In the random run that shows up at the first mismatched `out_data` word. A phase register that captures while the stage is full changes the stage's data while it is still being offered, and the directed hold checks see this within a few cycles. A C-element that is slow by an extra register shifts the two-edge capture latency that the directed cases sample.

// File: rtl/mt_pkg.sv
// Shared helpers for the two-phase fork/join stages.
package mt_pkg;
    // A stage is full when its done phase differs from the downstream ack phase.
    function automatic logic stage_full(input logic done_ph, input logic ack_ph);
        return done_ph ^ ack_ph;
    endfunction
endpackage

// File: rtl/mt_celem.sv
// Registered Muller C-element over N two-phase inputs.
// Assumes: inputs are two-phase wires that toggle at most once per item.
// The output copies the inputs when all agree, otherwise it keeps its value.
module mt_celem #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] in_vec,
    output logic         out_bit
);
    logic all_hi, all_lo;
    assign all_hi = &in_vec;
    assign all_lo = ~|in_vec;

    // Follow the inputs on agreement, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_bit <= 1'b0;
        else if (all_hi) out_bit <= 1'b1;
        else if (all_lo) out_bit <= 1'b0;
    end

    // R5
    celem_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_bit != $past(out_bit)) |-> ($past(in_vec) == {N{out_bit}}));
endmodule

// File: rtl/mt_fork_stage.sv
// Fork stage: captures one word and offers it to two branches on one request.
// The two branch acks are merged by a C-element; the XNOR of that merged ack
// with done opens the stage. Assumes branches ack only after seeing a request.
module mt_fork_stage
    import mt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up_req,
    input  logic [W-1:0] up_data,
    output logic         up_ack,
    output logic         dn_req,
    output logic [W-1:0] dn_data,
    input  logic         dn_ack_a,
    input  logic         dn_ack_b
);
    logic         ack_m;
    logic         done_q;
    logic [W-1:0] data_q;
    logic         open_en;

    mt_celem #(.N(2)) u_ack_c (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vec ({dn_ack_b, dn_ack_a}),
        .out_bit(ack_m)
    );

    assign open_en = ~stage_full(done_q, ack_m);

    // Capture a new item when open and the upstream phase differs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            data_q <= '0;
        end else if (open_en && (up_req != done_q)) begin
            done_q <= up_req;
            data_q <= up_data;
        end
    end

    assign up_ack  = done_q;
    assign dn_req  = done_q;
    assign dn_data = data_q;

    // R3
    fork_both_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q != $past(done_q)) |->
            ($past(dn_ack_a) == $past(done_q) && $past(dn_ack_b) == $past(done_q)));
    // R3
    fork_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_ack_a != done_q || dn_ack_b != done_q) |=> $stable(data_q));
endmodule

// File: rtl/mt_join_stage.sv
// Join stage: merges two branch requests with a C-element and captures both
// branch words as one concatenated word {A, B}. Assumes each branch holds its
// data stable from its request toggle until the join ack toggles.
module mt_join_stage
    import mt_pkg::*;
#(
    parameter int W  = 8,
    localparam int OW = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_req_a,
    input  logic [W-1:0]  up_data_a,
    input  logic          up_req_b,
    input  logic [W-1:0]  up_data_b,
    output logic          up_ack,
    output logic          dn_req,
    output logic [OW-1:0] dn_data,
    input  logic          dn_ack
);
    logic          req_m;
    logic          done_q;
    logic [OW-1:0] data_q;
    logic          open_en;

    mt_celem #(.N(2)) u_req_c (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vec ({up_req_b, up_req_a}),
        .out_bit(req_m)
    );

    assign open_en = ~stage_full(done_q, dn_ack);

    // Capture the pair when open and the merged request phase differs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            data_q <= '0;
        end else if (open_en && (req_m != done_q)) begin
            done_q <= req_m;
            data_q <= {up_data_a, up_data_b};
        end
    end

    assign up_ack  = done_q;
    assign dn_req  = done_q;
    assign dn_data = data_q;

    // R6
    join_both_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q != $past(done_q)) |->
            ($past(up_req_a) == done_q && $past(up_req_b) == done_q));
    // R8
    join_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_ack != done_q) |=> ($stable(data_q) && $stable(done_q)));
endmodule

// File: rtl/mt_fork_join.sv
// Top: one fork stage and one join stage of a two-phase latch pipeline.
// The two branch pipelines between them are outside this block.
module mt_fork_join #(
    parameter int W  = 8,
    localparam int OW = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_req,
    input  logic [W-1:0]  in_data,
    output logic          in_ack,
    output logic          fork_req,
    output logic [W-1:0]  fork_data,
    input  logic          fork_ack_a,
    input  logic          fork_ack_b,
    input  logic          join_req_a,
    input  logic [W-1:0]  join_data_a,
    input  logic          join_req_b,
    input  logic [W-1:0]  join_data_b,
    output logic          join_ack,
    output logic          out_req,
    output logic [OW-1:0] out_data,
    input  logic          out_ack
);
    mt_fork_stage #(.W(W)) u_fork (
        .clk     (clk),
        .rst_n   (rst_n),
        .up_req  (in_req),
        .up_data (in_data),
        .up_ack  (in_ack),
        .dn_req  (fork_req),
        .dn_data (fork_data),
        .dn_ack_a(fork_ack_a),
        .dn_ack_b(fork_ack_b)
    );

    mt_join_stage #(.W(W)) u_join (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_req_a (join_req_a),
        .up_data_a(join_data_a),
        .up_req_b (join_req_b),
        .up_data_b(join_data_b),
        .up_ack   (join_ack),
        .dn_req   (out_req),
        .dn_data  (out_data),
        .dn_ack   (out_ack)
    );

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!in_ack && !fork_req && !join_ack && !out_req));
endmodule

// File: tb/mt_fork_join_tb_top.sv
module mt_fork_join_tb_top;
    localparam int W = 8;
    localparam int NITEMS = 300;
    localparam int LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic in_req = 0, fork_ack_a = 0, fork_ack_b = 0;
    logic join_req_a = 0, join_req_b = 0, out_ack = 0;
    logic [W-1:0] in_data = '0, join_data_a = '0, join_data_b = '0;
    logic in_ack, fork_req, join_ack, out_req;
    logic [W-1:0] fork_data;
    logic [2*W-1:0] out_data;

    int checks = 0, fails = 0, cyc = 0, got = 0;
    logic auto_en = 0;
    logic [W-1:0] qa[$];
    logic [W-1:0] qb[$];

    mt_fork_join #(.W(W)) dut_i (.*);

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [W-1:0] item_word(input int i);
        return W'((i * 37 + 5) & 255);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Branch model: a small FIFO with random accept and emit delays.
    task automatic branch(input int id);
        forever begin
            @(negedge clk);
            if (auto_en) begin
                if (id == 0) begin
                    if (fork_req != fork_ack_a && qa.size() < 3 && $urandom_range(0, 2) == 0) begin
                        qa.push_back(fork_data); fork_ack_a = fork_req;
                    end
                    if (join_req_a == join_ack && qa.size() > 0 && $urandom_range(0, 3) == 0) begin
                        join_data_a = qa.pop_front(); join_req_a = ~join_req_a;
                    end
                end else begin
                    if (fork_req != fork_ack_b && qb.size() < 3 && $urandom_range(0, 1) == 0) begin
                        qb.push_back(fork_data); fork_ack_b = fork_req;
                    end
                    if (join_req_b == join_ack && qb.size() > 0 && $urandom_range(0, 4) == 0) begin
                        join_data_b = qb.pop_front(); join_req_b = ~join_req_b;
                    end
                end
            end
        end
    endtask

    task automatic producer();
        for (int i = 0; i < NITEMS; i++) begin
            while (in_ack != in_req) @(negedge clk);
            step($urandom_range(0, 2));
            in_data = item_word(i);
            in_req = ~in_req;
            @(negedge clk);
        end
    endtask

    task automatic consumer();
        forever begin
            @(negedge clk);
            if (out_req != out_ack && $urandom_range(0, 2) == 0) begin
                // R9: n-th output pairs the n-th input on both halves
                check("R9", 32'(out_data), 32'({item_word(got), item_word(got)}));
                got++;
                out_ack = out_req;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", {in_ack, fork_req, join_ack, out_req}, 0);
        check("R1", 32'(fork_data), 0);
        check("R1", 32'(out_data), 0);

        // R2: empty fork captures at the next edge
        in_data = 8'hA5; in_req = 1;
        @(negedge clk);
        check("R2", {fork_req, in_ack}, 2'b11);
        check("R2", 32'(fork_data), 32'hA5);

        // R3: only branch A acks; new input must not enter
        fork_ack_a = 1; in_data = 8'h3C; in_req = 0;
        step(3);
        check("R3", {fork_req, in_ack}, 2'b11);
        check("R3", 32'(fork_data), 32'hA5);

        // R4/R5: branch B acks; C-element updates, capture one edge later
        fork_ack_b = 1;
        @(negedge clk);
        check("R5", 32'(fork_req), 1);
        @(negedge clk);
        check("R4", 32'(fork_req), 0);
        check("R4", 32'(fork_data), 32'h3C);
        fork_ack_a = 0; fork_ack_b = 0;
        step(3);

        // R6: one join request alone has no effect
        join_data_a = 8'h11; join_req_a = 1;
        step(3);
        check("R6", {out_req, join_ack}, 0);
        check("R6", 32'(out_data), 0);

        // R7: second request; capture at the second edge after it
        join_data_b = 8'h22; join_req_b = 1;
        @(negedge clk);
        check("R7", 32'(out_req), 0);
        @(negedge clk);
        check("R7", {out_req, join_ack}, 2'b11);
        check("R7", 32'(out_data), 32'h1122);

        // R8: consumer has not acked; new pair must wait
        join_data_a = 8'h33; join_data_b = 8'h44; join_req_a = 0; join_req_b = 0;
        step(4);
        check("R8", 32'(out_data), 32'h1122);
        check("R8", 32'(out_req), 1);
        out_ack = 1;
        @(negedge clk);
        check("R8", 32'(out_data), 32'h3344);
        check("R8", 32'(out_req), 0);
        out_ack = 0;
        step(3);

        // R9: random end-to-end run through two independent branches
        auto_en = 1;
        fork
            branch(0);
            branch(1);
            consumer();
            producer();
        join_none
        while (got < NITEMS && cyc < LIMIT) @(negedge clk);
        if (got < NITEMS) check("R9 watchdog", got, NITEMS);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule